// File: doc/BRIEF.md
# Dual-Window Bitstream Accumulator

This block turns a one-bit sigma-delta stream into two integrated samples per conversion window. A single start pulse, together with a half-length N, opens a window that lasts 2N clock cycles. During that window the block keeps two running totals. The flat total adds 1 on every cycle where the stream bit is high. The ramped total adds a weight that rises by one each cycle from 1 up to N, holds N for one more cycle, and then falls back to 1. The ramped total therefore applies a triangular window, which suppresses a first-order modulator's quantisation noise far better than the flat count.

At the end of the window both totals are copied into output registers. A one-cycle valid strobe marks them, and they stay unchanged until the next window ends. Both accumulators clear when a window opens, so every window stands alone. A new start is accepted in the same cycle as the strobe. Software or a sequencer chooses N and issues the start pulses. The block itself has no bus interface.

Top module: `dual_window_accum`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, both result outputs are 0, and the block is idle.
- R2: `rect_out` equals the number of cycles with `bit_in`=1 over the 2N sampling edges of a window, where N is `half_len` taken at the accepted start.
- R3: Sampling edge k (k=0..2N-1) carries weight k+1 for k<N and 2N-k otherwise. `tri_out` is the sum of the weights of edges where `bit_in`=1.
- R4: A start is accepted on the clock edge where `start`=1 and the block is idle. The 2N edges that follow are the sampling edges. `out_valid` is 1 for exactly the one cycle after the last sampling edge.
- R5: Between strobes, `rect_out` and `tri_out` hold their last captured values.
- R6: While a window is running, `start` and changes on `half_len` have no effect on that window's results or length.
- R7: Both accumulators clear when a window is accepted, so back-to-back windows give independent results.
- R8: A start with `half_len`=0 is ignored: no window opens, no strobe follows, and the outputs are unchanged.
- R9: With N at its maximum and `bit_in` held at 1, the results are 2N and N(N+1), with no wrap-around.
- R10: A start given in the cycle where `out_valid` is 1 is accepted, and that window's results are unaffected by the previous window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Window start request, one cycle |
| half_len | input | HALF_W | Half-length N of the window |
| bit_in | input | 1 | Modulator bitstream |
| rect_out | output | 2*HALF_W+1 | Flat-window result |
| tri_out | output | 2*HALF_W+1 | Triangular-window result |
| out_valid | output | 1 | One-cycle strobe for new results |

## Verification
Assertions check, on every cycle, a set of structural properties:
- the ramp weight stays between 1 and the latched N, and changes by at most one per step;
- the latched length stays frozen while a window runs;
- the accumulators never wrap;
- the strobe lasts a single cycle;
- at each strobe, the flat result is at most 2N and never larger than the triangular result.

The exact totals can only be shown by the bench scenarios. These cover sweeps over N with several bit patterns, with expected sums computed arithmetically. The same scenarios cover the ignored-start cases, the zero-length start, back-to-back chaining and full-scale input.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

    typedef enum logic {
        RAMP_UP   = 1'b0,
        RAMP_DOWN = 1'b1
    } ramp_dir_e;

    // per-cycle control from the window sequencer to the datapath
    typedef struct packed {
        logic clear;   // window accepted on this edge
        logic step;    // this edge is a sampling edge
        logic last;    // this edge is the final sampling edge
    } step_ctl_t;

    // result width: holds N*(N+1) for N < 2**hw
    function automatic int unsigned acc_width(int unsigned hw);
        return 2 * hw + 1;
    endfunction

endpackage

// File: rtl/dwa_window_ctrl.sv
module dwa_window_ctrl
    import dwa_pkg::*;
#(
    parameter int unsigned HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [HALF_W-1:0] half_len,
    output step_ctl_t         ctl,
    output logic [HALF_W-1:0] n_lat
);
    localparam int unsigned CNT_W = HALF_W + 1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{HALF_W{1'b0}}, 1'b1};

    logic             running;
    logic [CNT_W-1:0] remaining;
    logic             accept;

    assign accept    = !running && start && (half_len != '0);
    assign ctl.clear = accept;
    assign ctl.step  = running;
    assign ctl.last  = running && (remaining == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            remaining <= '0;
            n_lat     <= '0;
        end else if (accept) begin
            running   <= 1'b1;
            n_lat     <= half_len;
            remaining <= {half_len, 1'b0} - CNT_ONE;
        end else if (running) begin
            if (remaining == '0) begin
                running <= 1'b0;
            end else begin
                remaining <= remaining - CNT_ONE;
            end
        end
    end

    // R6: a running window keeps its length and keeps running until its last edge
    a_r6_len_frozen: assert property (@(posedge clk) disable iff (rst)
        (running && !ctl.last) |=> (running && $stable(n_lat)));

    // R4: the window closes right after its final sampling edge
    a_r4_window_closes: assert property (@(posedge clk) disable iff (rst)
        ctl.last |=> !running);

    // R8: a zero half-length never opens a window
    a_r8_zero_len: assert property (@(posedge clk) disable iff (rst)
        (!running && (half_len == '0)) |=> !running);

endmodule

// File: rtl/dwa_tri_ramp.sv
module dwa_tri_ramp
    import dwa_pkg::*;
#(
    parameter int unsigned HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  logic [HALF_W-1:0] n_max,
    output logic [HALF_W-1:0] weight
);
    localparam logic [HALF_W-1:0] W_ONE = {{(HALF_W-1){1'b0}}, 1'b1};

    ramp_dir_e dir;

    always_ff @(posedge clk) begin
        if (rst) begin
            weight <= W_ONE;
            dir    <= RAMP_UP;
        end else if (clear) begin
            weight <= W_ONE;
            dir    <= RAMP_UP;
        end else if (step) begin
            if (dir == RAMP_UP) begin
                if (weight == n_max) begin
                    dir <= RAMP_DOWN;      // peak weight repeats once
                end else begin
                    weight <= weight + W_ONE;
                end
            end else if (weight != W_ONE) begin
                weight <= weight - W_ONE;
            end
        end
    end

    // R3: the weight in use stays inside 1..N
    a_r3_weight_range: assert property (@(posedge clk) disable iff (rst)
        step |-> ((weight != '0) && (weight <= n_max)));

    // R3: consecutive steps change the weight by at most one
    a_r3_weight_slope: assert property (@(posedge clk) disable iff (rst)
        step |=> (!step || (weight == $past(weight)) ||
                  (weight == $past(weight) + W_ONE) ||
                  (weight + W_ONE == $past(weight))));

endmodule

// File: rtl/dwa_accum.sv
module dwa_accum #(
    parameter int unsigned ACC_W = 17,
    parameter int unsigned WT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic             last,
    input  logic             bit_in,
    input  logic [WT_W-1:0]  weight,
    output logic [ACC_W-1:0] result
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] addend;
    logic [ACC_W-1:0] sum;

    assign addend = bit_in ? {{(ACC_W-WT_W){1'b0}}, weight} : '0;
    assign sum    = acc + addend;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            result <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (step) begin
            acc <= sum;
            if (last) begin
                result <= sum;
            end
        end
    end

    // R9: the running total never wraps
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
        step |-> (sum >= acc));

    // R5: the captured result changes only on a final step
    a_r5_result_hold: assert property (@(posedge clk) disable iff (rst)
        !(step && last) |=> $stable(result));

endmodule

// File: rtl/dual_window_accum.sv
module dual_window_accum
    import dwa_pkg::*;
#(
    parameter int unsigned HALF_W = 8,
    localparam int unsigned ACC_W = acc_width(HALF_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [HALF_W-1:0] half_len,
    input  logic              bit_in,
    output logic [ACC_W-1:0]  rect_out,
    output logic [ACC_W-1:0]  tri_out,
    output logic              out_valid
);
    localparam int unsigned N_CH = 2;   // channel 0 flat, channel 1 triangular
    localparam logic [HALF_W-1:0] W_ONE = {{(HALF_W-1){1'b0}}, 1'b1};

    step_ctl_t         ctl;
    logic [HALF_W-1:0] n_lat;
    logic [HALF_W-1:0] ramp_w;
    logic [ACC_W-1:0]  ch_result [N_CH];

    dwa_window_ctrl #(.HALF_W(HALF_W)) i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .half_len (half_len),
        .ctl      (ctl),
        .n_lat    (n_lat)
    );

    dwa_tri_ramp #(.HALF_W(HALF_W)) i_ramp (
        .clk    (clk),
        .rst    (rst),
        .clear  (ctl.clear),
        .step   (ctl.step),
        .n_max  (n_lat),
        .weight (ramp_w)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic [HALF_W-1:0] ch_wt;
        if (g == 0) begin : g_flat
            assign ch_wt = W_ONE;
        end else begin : g_ramp
            assign ch_wt = ramp_w;
        end
        dwa_accum #(.ACC_W(ACC_W), .WT_W(HALF_W)) i_acc (
            .clk    (clk),
            .rst    (rst),
            .clear  (ctl.clear),
            .step   (ctl.step),
            .last   (ctl.last),
            .bit_in (bit_in),
            .weight (ch_wt),
            .result (ch_result[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= ctl.last;
        end
    end

    assign rect_out = ch_result[0];
    assign tri_out  = ch_result[1];

    logic [ACC_W-1:0] n_ext;
    assign n_ext = {{(ACC_W-HALF_W){1'b0}}, n_lat};

    // R4: the strobe lasts one cycle
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R2: the flat count cannot exceed the window length
    a_r2_rect_bound: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (rect_out <= (n_ext << 1)));

    // R3: every weight is at least one, and the triangle area bounds the total
    a_r3_tri_bounds: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((tri_out >= rect_out) &&
                       (tri_out <= n_ext * (n_ext + 1'b1))));

endmodule

// File: tb/test_dual_window_accum.sv
module test_dual_window_accum;
    localparam int HW = 8;
    localparam int AW = 2 * HW + 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [HW-1:0] half_len;
    logic          bit_in;
    logic [AW-1:0] rect_out;
    logic [AW-1:0] tri_out;
    logic          out_valid;

    int n_checks = 0;
    int n_bad    = 0;
    int cycles   = 0;
    int last_rect = 0;
    int last_tri  = 0;

    always #2ns clk = ~clk;

    dual_window_accum #(.HALF_W(HW)) i_dual_window_accum (
        .clk(clk), .rst(rst), .start(start), .half_len(half_len),
        .bit_in(bit_in), .rect_out(rect_out), .tri_out(tri_out),
        .out_valid(out_valid)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", n_checks + 1, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pat(input int kind, input int k, input int seed);
        case (kind)
            0:       return 1'b1;
            1:       return 1'b0;
            2:       return logic'(k % 2);
            default: return ((k * 7 + seed * 3) % 5) < 2;
        endcase
    endfunction

    // Entered just after a negedge; leaves just after a negedge.
    // inject: pulse start with another length mid-window (R6)
    // chain: skip the hold check so the next window starts in the strobe cycle (R10)
    task automatic run_window(input int n, input int kind, input int seed,
                              input bit inject, input bit chain, input string req);
        int exp_r = 0;
        int exp_t = 0;
        int early_valid = 0;
        start    = 1'b1;
        half_len = HW'(n);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 2 * n; k++) begin
            logic b;
            int   w;
            b = pat(kind, k, seed);
            w = (k < n) ? k + 1 : 2 * n - k;
            bit_in = b;
            if (b) begin
                exp_r += 1;
                exp_t += w;
            end
            if (out_valid) early_valid++;
            if (inject && k == n)     begin start = 1'b1; half_len = HW'(3); end
            if (inject && k == n + 1) begin start = 1'b0; half_len = HW'(n); end
            @(negedge clk);
        end
        start = 1'b0;
        chk({req, " R4 no strobe inside window"}, early_valid, 0);
        chk({req, " R4 strobe after last edge"}, int'(out_valid), 1);
        chk({req, " R2 flat total"}, int'(rect_out), exp_r);
        chk({req, " R3 triangular total"}, int'(tri_out), exp_t);
        last_rect = exp_r;
        last_tri  = exp_t;
        if (!chain) begin
            bit_in = 1'b1;
            @(negedge clk);
            chk({req, " R4 strobe single cycle"}, int'(out_valid), 0);
            chk({req, " R5 flat held"}, int'(rect_out), exp_r);
            chk({req, " R5 tri held"}, int'(tri_out), exp_t);
            bit_in = 1'b0;
        end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; half_len = '0; bit_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", int'(out_valid), 0);
        chk("R1 rect after reset", int'(rect_out), 0);
        chk("R1 tri after reset", int'(tri_out), 0);

        // sweep N and patterns (R2, R3, R4, R5)
        for (int n = 1; n <= 8; n++) begin
            for (int kind = 0; kind < 4; kind++) begin
                run_window(n, kind, n + kind, 1'b0, 1'b0, "sweep");
            end
        end

        // R6: start and a new length during a window are ignored
        run_window(6, 3, 9, 1'b1, 1'b0, "R6 busy start");
        run_window(5, 0, 0, 1'b1, 1'b0, "R6 busy start ones");

        // R8: zero length start is ignored
        start = 1'b1; half_len = '0; bit_in = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 6; i++) begin
                if (out_valid) seen++;
                @(negedge clk);
            end
            chk("R8 no strobe for zero length", seen, 0);
            chk("R8 rect unchanged", int'(rect_out), last_rect);
            chk("R8 tri unchanged", int'(tri_out), last_tri);
        end
        bit_in = 1'b0;

        // R7 / R10: back-to-back windows, second starts in the strobe cycle
        run_window(4, 0, 0, 1'b0, 1'b1, "R10 first");
        run_window(3, 1, 0, 1'b0, 1'b1, "R7 R10 second zeros");
        run_window(2, 2, 0, 1'b0, 1'b0, "R7 R10 third");

        // R9: full scale
        run_window((1 << HW) - 1, 0, 0, 1'b0, 1'b0, "R9 full scale");
        chk("R9 rect full scale", int'(rect_out), 2 * ((1 << HW) - 1));
        chk("R9 tri full scale", int'(tri_out), ((1 << HW) - 1) * (1 << HW));

        // R1: reset clears captured results
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rect cleared by reset", int'(rect_out), 0);
        chk("R1 tri cleared by reset", int'(tri_out), 0);

        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule